// File: doc/BRIEF.md
# Sync Source Identifier and Router

This block sits behind the slicers of a multi-scan display front end. It receives three sync lines that are already digital. The first is a separate vertical sync. The second is a line that carries either horizontal sync or composite sync. The third is the sync extracted from a sync-on-video signal, active low. A fourth input gives a vertical pulse that upstream logic has already separated out of the composite or video sync, with positive polarity.

For the separate vertical line and the horizontal/composite line, the block decides whether the line is active and which polarity it has. It then picks the sources for a vertical drive output and a horizontal drive output. Both drive outputs always have positive polarity. The block also raises a negative-polarity flag for each of the two channels.

A select input decides whether horizontal drive is suppressed while vertical drive is high. Suppression is only possible when horizontal drive does not come from a separate horizontal sync.

The routing decision is held in a four-state machine:

- `SRC_SEPARATE`: both lines are active. Vertical drive comes from the separate vertical line and horizontal drive comes from the horizontal line.
- `SRC_COMPOSITE`: only the horizontal/composite line is active. Vertical drive comes from the separated vertical pulse and horizontal drive comes from the composite line.
- `SRC_VSEP_VIDEO`: only the separate vertical line is active. Vertical drive comes from that line and horizontal drive comes from video sync.
- `SRC_VIDEO`: neither line is active, which is also the state after reset. Vertical drive comes from the separated vertical pulse and horizontal drive comes from video sync.

There is one transition rule, and it holds for every state. On each clock the machine moves to the state named by the current pair of activity flags. This covers the transitions to `SRC_SEPARATE` when both lines are present, to `SRC_COMPOSITE` when only the horizontal line is present, to `SRC_VSEP_VIDEO` when only the vertical line is present, and to `SRC_VIDEO` when neither is present.

Top module: `sync_router`

## Requirements
- R1: A line is declared active once it has made ACQ_EDGES level changes, each within the timeout of the one before. It is declared inactive only after a full timeout (H_TIMEOUT or V_TIMEOUT cycles) passes with no level change, so a single late pulse does not clear it.
- R2: A line's polarity is judged once per window (H_WIN or V_WIN cycles). It is negative when the line was high for more than half the window, and positive otherwise.
- R3: With both lines active, vdrv follows the separate vertical line and hdrv follows the horizontal line, each inverted if its polarity is negative.
- R4: With only the horizontal/composite line active, vdrv follows `vsx_in` and hdrv follows the composite line, inverted if its polarity is negative.
- R5: With only the separate vertical line active, vdrv follows that line, inverted if its polarity is negative, and hdrv follows the inverse of `vid_in`.
- R6: With neither line active, vdrv follows `vsx_in` and hdrv follows the inverse of `vid_in`.
- R7: `hpol_neg` is 1 only when the horizontal/composite line is active and negative. It is 0 for positive polarity or no signal.
- R8: `vpol_neg` is 1 only when the separate vertical line is active and negative. It is 0 when that line is positive or absent, including when only composite sync is present.
- R9: When `hsel` is 0 and the source is not `SRC_SEPARATE`, hdrv is 0 in every cycle in which vdrv is 1.
- R10: When `hsel` is 1, hdrv follows its source through the vertical interval.
- R11: In `SRC_SEPARATE`, hdrv follows the horizontal line whatever the value of `hsel`.
- R12: All four outputs are registered. Each reflects the inputs sampled at the same clock edge. All four are 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsep_in | input | 1 | Separate vertical sync, either polarity |
| hcs_in | input | 1 | Horizontal or composite sync, either polarity |
| vid_in | input | 1 | Sync from sync-on-video, active low |
| vsx_in | input | 1 | Vertical pulse separated from composite or video sync, active high |
| hsel | input | 1 | 1 keeps horizontal drive on during the vertical interval |
| vdrv | output | 1 | Vertical drive, positive polarity |
| hdrv | output | 1 | Horizontal drive, positive polarity |
| hpol_neg | output | 1 | Horizontal/composite line is active and negative |
| vpol_neg | output | 1 | Separate vertical line is active and negative |

## Verification
Some rules hold on every clock edge, and the assertions check these. The polarity flags are raised only for a line that was active. The state tracks the pair of activity flags. Horizontal drive is held low inside the vertical interval when the select is low and the source is not separate sync. In the separate state, horizontal drive passes the normalised horizontal line.

Other behaviours need time and a known input waveform, so only the bench scenarios can show them. These are the exact waveform each drive output carries for each source combination and polarity, how the polarity decision reacts to duty cycle, and the hysteresis in the activity timeout.

// File: rtl/sync_router_pkg.sv
package sync_router_pkg;

    typedef enum logic [1:0] {
        SRC_VIDEO      = 2'd0,
        SRC_VSEP_VIDEO = 2'd1,
        SRC_COMPOSITE  = 2'd2,
        SRC_SEPARATE   = 2'd3
    } src_state_e;

endpackage

// File: rtl/sync_activity.sv
module sync_activity #(
    parameter int unsigned TIMEOUT   = 1500,
    parameter int unsigned ACQ_EDGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic present
);
    localparam int unsigned CW = $clog2(TIMEOUT + 1);
    localparam int unsigned EW = $clog2(ACQ_EDGES + 1);

    logic          prev;
    logic [CW-1:0] idle;
    logic [EW-1:0] hits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev    <= 1'b0;
            idle    <= '0;
            hits    <= '0;
            present <= 1'b0;
        end else begin
            prev <= din;
            if (din != prev) begin
                idle <= '0;
                if (!present) begin
                    if (hits == EW'(ACQ_EDGES - 1)) begin
                        present <= 1'b1;
                        hits    <= '0;
                    end else begin
                        hits <= hits + 1'b1;
                    end
                end
            end else if (idle != CW'(TIMEOUT)) begin
                idle <= idle + 1'b1;
                if (idle == CW'(TIMEOUT - 1)) begin
                    present <= 1'b0;
                    hits    <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/sync_polarity.sv
module sync_polarity #(
    parameter int unsigned WIN = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic neg
);
    localparam int unsigned WW = $clog2(WIN + 1);

    logic [WW-1:0] pos;
    logic [WW-1:0] highs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos   <= '0;
            highs <= '0;
            neg   <= 1'b0;
        end else if (pos == WW'(WIN - 1)) begin
            neg   <= (highs + WW'(din)) > WW'(WIN / 2);
            pos   <= '0;
            highs <= '0;
        end else begin
            pos   <= pos + 1'b1;
            highs <= highs + WW'(din);
        end
    end
endmodule

// File: rtl/sync_router.sv
module sync_router
    import sync_router_pkg::*;
#(
    parameter int unsigned H_TIMEOUT = 1500,
    parameter int unsigned V_TIMEOUT = 1500000,
    parameter int unsigned ACQ_EDGES = 3,
    parameter int unsigned H_WIN     = 16384,
    parameter int unsigned V_WIN     = 4194304
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsep_in,
    input  logic hcs_in,
    input  logic vid_in,
    input  logic vsx_in,
    input  logic hsel,
    output logic vdrv,
    output logic hdrv,
    output logic hpol_neg,
    output logic vpol_neg
);
    logic vs_act, hc_act, vs_neg, hc_neg;
    src_state_e state, nxt;
    logic v_sel, h_sel, may_blank, h_gate;
    logic vs_pos, hc_pos, vid_pos;

    sync_activity #(.TIMEOUT(V_TIMEOUT), .ACQ_EDGES(ACQ_EDGES)) u_vs_act (
        .clk(clk), .rst_n(rst_n), .din(vsep_in), .present(vs_act));
    sync_activity #(.TIMEOUT(H_TIMEOUT), .ACQ_EDGES(ACQ_EDGES)) u_hc_act (
        .clk(clk), .rst_n(rst_n), .din(hcs_in), .present(hc_act));
    sync_polarity #(.WIN(V_WIN)) u_vs_pol (
        .clk(clk), .rst_n(rst_n), .din(vsep_in), .neg(vs_neg));
    sync_polarity #(.WIN(H_WIN)) u_hc_pol (
        .clk(clk), .rst_n(rst_n), .din(hcs_in), .neg(hc_neg));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SRC_VIDEO;
        else        state <= nxt;
    end

    // every state moves to the one named by the activity pair
    always_comb begin
        unique case ({vs_act, hc_act})
            2'b11:   nxt = SRC_SEPARATE;
            2'b01:   nxt = SRC_COMPOSITE;
            2'b10:   nxt = SRC_VSEP_VIDEO;
            default: nxt = SRC_VIDEO;
        endcase
    end

    assign vs_pos  = vsep_in ^ vs_neg;
    assign hc_pos  = hcs_in ^ hc_neg;
    assign vid_pos = ~vid_in;

    always_comb begin
        unique case (state)
            SRC_SEPARATE: begin
                v_sel = vs_pos;  h_sel = hc_pos;  may_blank = 1'b0;
            end
            SRC_COMPOSITE: begin
                v_sel = vsx_in;  h_sel = hc_pos;  may_blank = 1'b1;
            end
            SRC_VSEP_VIDEO: begin
                v_sel = vs_pos;  h_sel = vid_pos; may_blank = 1'b1;
            end
            default: begin
                v_sel = vsx_in;  h_sel = vid_pos; may_blank = 1'b1;
            end
        endcase
    end

    assign h_gate = h_sel & ~(may_blank & ~hsel & v_sel);

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vdrv     <= 1'b0;
            hdrv     <= 1'b0;
            hpol_neg <= 1'b0;
            vpol_neg <= 1'b0;
        end else begin
            vdrv     <= v_sel;
            hdrv     <= h_gate;
            hpol_neg <= hc_act & hc_neg;
            vpol_neg <= vs_act & vs_neg;
        end
    end
endmodule

// File: rtl/sync_router_chk.sv
module sync_router_chk
    import sync_router_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       hsel,
    input logic       hcs_in,
    input logic       vdrv,
    input logic       hdrv,
    input logic       hpol_neg,
    input logic       vpol_neg,
    input logic       vs_act,
    input logic       hc_act,
    input logic       hc_neg,
    input src_state_e state
);
    AST_HPOL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        hpol_neg |-> $past(hc_act));                                          // R7
    AST_VPOL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        vpol_neg |-> $past(vs_act));                                          // R8
    AST_SRC_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vs_act && hc_act) |-> state == SRC_SEPARATE);                   // R3
    AST_SRC_COMPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!vs_act && hc_act) |-> state == SRC_COMPOSITE);                 // R4
    AST_BLANK_LOW_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(hsel) && vdrv && $past(state) != SRC_SEPARATE) |-> !hdrv);    // R9
    AST_SEP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == SRC_SEPARATE && $past(hcs_in ^ hc_neg)) |-> hdrv);  // R11
endmodule

bind sync_router sync_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .hcs_in(hcs_in),
    .vdrv(vdrv), .hdrv(hdrv), .hpol_neg(hpol_neg), .vpol_neg(vpol_neg),
    .vs_act(vs_act), .hc_act(hc_act), .hc_neg(hc_neg), .state(state)
);

// File: tb/sync_router_test.sv
module sync_router_test;
    localparam int CLK_P = 10;
    localparam int HTO   = 40;
    localparam int VTO   = 400;
    localparam int HP = 20, HW = 3, VP = 200, VW = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic vsep_in = 1'b0, hcs_in = 1'b0, vid_in = 1'b1, vsx_in = 1'b0, hsel = 1'b0;
    logic vdrv, hdrv, hpol_neg, vpol_neg;

    bit h_en = 0, h_neg = 0, v_en = 0, v_neg = 0, vid_en = 0, vsx_en = 0, sel = 0;
    int h_ph = 0, v_ph = 0;
    int checks = 0, fails = 0;

    always #(CLK_P/2) clk = ~clk;

    sync_router #(.H_TIMEOUT(HTO), .V_TIMEOUT(VTO), .ACQ_EDGES(3),
                  .H_WIN(256), .V_WIN(2048)) uut (
        .clk(clk), .rst_n(rst_n), .vsep_in(vsep_in), .hcs_in(hcs_in),
        .vid_in(vid_in), .vsx_in(vsx_in), .hsel(hsel), .vdrv(vdrv),
        .hdrv(hdrv), .hpol_neg(hpol_neg), .vpol_neg(vpol_neg));

    // stimulus generator, changes inputs on the falling edge only
    always @(negedge clk) begin
        h_ph    = (h_ph + 1) % HP;
        v_ph    = (v_ph + 1) % VP;
        hcs_in  <= h_en ? ((h_ph < HW) ^ h_neg) : h_neg;
        vsep_in <= v_en ? ((v_ph < VW) ^ v_neg) : v_neg;
        vid_in  <= vid_en ? !(h_ph < HW) : 1'b1;
        vsx_in  <= vsx_en ? (v_ph < VW) : 1'b0;
        hsel    <= sel;
    end

    task automatic check(input string rq, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", rq, what, act, exp);
        end
    endtask

    task automatic setup(input bit he, input bit hn, input bit ve, input bit vn,
                         input bit de, input bit xe, input bit s);
        @(negedge clk);
        h_en = he; h_neg = hn; v_en = ve; v_neg = vn; vid_en = de; vsx_en = xe; sel = s;
        repeat (5000) @(posedge clk);
    endtask

    // mode: 3 separate, 2 composite, 1 vertical+video, 0 video
    task automatic run_route(input int mode, input bit ehp, input bit evp,
                             input string rq_route, input string rq_flag);
        logic ev, eh, av, ah, xv, xh;
        bit blank, bv = 0, bh = 0;
        av = 0; ah = 0; xv = 0; xh = 0;
        for (int i = 0; i < 600; i++) begin
            @(posedge clk); #1;
            blank = (mode != 3);
            ev = (mode == 3 || mode == 1) ? (vsep_in ^ v_neg) : vsx_in;
            eh = (mode >= 2) ? (hcs_in ^ h_neg) : !vid_in;
            if (blank && !hsel && ev) eh = 1'b0;
            if (vdrv !== ev && !bv) begin bv = 1; av = vdrv; xv = ev; end
            if (hdrv !== eh && !bh) begin bh = 1; ah = hdrv; xh = eh; end
        end
        check(rq_route, "vdrv waveform", bv ? av : 1'b0, bv ? xv : 1'b0);
        check(rq_route, "hdrv waveform", bh ? ah : 1'b0, bh ? xh : 1'b0);
        check(rq_flag, "hpol_neg", hpol_neg, ehp);
        check(rq_flag, "vpol_neg", vpol_neg, evp);
    endtask

    task automatic t_reset;
        repeat (4) @(posedge clk); #1;
        check("R12", "vdrv in reset", vdrv, 1'b0);
        check("R12", "hdrv in reset", hdrv, 1'b0);
        check("R12", "hpol_neg in reset", hpol_neg, 1'b0);
        check("R12", "vpol_neg in reset", vpol_neg, 1'b0);
    endtask

    task automatic t_sep_pos;   // R3 R11 with hsel low
        setup(1, 0, 1, 0, 1, 1, 0);
        run_route(3, 0, 0, "R3/R11/R12", "R7/R8 positive");
    endtask

    task automatic t_sep_neg;   // R3 and R2 on both lines
        setup(1, 1, 1, 1, 0, 0, 1);
        run_route(3, 1, 1, "R3", "R2/R7/R8 negative");
    endtask

    task automatic t_drop;      // R1 timeout hysteresis
        @(negedge clk); h_en = 0;
        repeat (HTO - 25) @(posedge clk); #1;
        check("R1", "hpol_neg before timeout", hpol_neg, 1'b1);
        repeat (30) @(posedge clk); #1;
        check("R1", "hpol_neg after timeout", hpol_neg, 1'b0);
    endtask

    task automatic t_comp_low;  // R4 R9
        setup(1, 1, 0, 1, 0, 1, 0);
        run_route(2, 1, 0, "R4/R9", "R8 composite only");
    endtask

    task automatic t_comp_high; // R4 R10
        setup(1, 0, 0, 0, 0, 1, 1);
        run_route(2, 0, 0, "R4/R10", "R7 positive composite");
    endtask

    task automatic t_vsep_vid;  // R5 R9
        setup(0, 0, 1, 1, 1, 0, 0);
        run_route(1, 0, 1, "R5/R9", "R7 absent/R8 negative");
    endtask

    task automatic t_video;     // R6 R10
        setup(0, 0, 0, 0, 1, 1, 1);
        run_route(0, 0, 0, "R6/R10", "R7/R8 absent");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_sep_pos();
        t_sep_neg();
        t_drop();
        t_comp_low();
        t_comp_high();
        t_vsep_vid();
        t_video();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule